// File: doc/BRIEF.md
# Three-Channel Phase-Staggered Cycle Clock with External Lock

The block produces the cycle-start pulses for three switching converter channels. An internal counter on the fast system clock is the oscillator. It wraps once per nominal switching period and fires a one-cycle start pulse. Channels one and two fire together. Channel three fires half a period later, which spreads the input current drawn by the three channels.

An asynchronous sync pin can take over the timing, but only after the power-good input is high. The pin is synchronized, and the block measures each period and high time in system-clock cycles. A period is valid when the source is faster than the internal oscillator (with margin), not above the maximum trackable frequency, and within the allowed duty range. After enough valid periods in a row, each sync rising edge restarts the internal counter. Channel three is then placed at half of the last accepted period. If the edges stop, the free-running counter continues from the last restart, so no cycle is lost, and the lock is dropped after a timeout. A fault flag shows a sync source that is present but unacceptable.

Top module: `multiphase_clk`

## Requirements
- R1: With no lock, channel one pulses for exactly one cycle every INT_PER = CLK_HZ/FSW_HZ system cycles.
- R2: Channels one and two pulse in the same cycle. Channel three never pulses together with channel one. With no lock it pulses INT_PER/2 cycles after channel one.
- R3: While pg_i is low, the sync pin has no effect: sync_ext_o stays low, sync_fault_o stays low, and the internal period is kept. Dropping pg_i clears an existing lock within one cycle.
- R4: A measured sync period P (cycles between rising edges) is valid only if ceil(CLK_HZ/SYNC_MAX_HZ) <= P <= floor(CLK_HZ/SYNC_MIN_HZ). With the defaults this is 22 to 47 cycles.
- R5: A period is valid only if its high time H satisfies 40*P <= 100*H <= 60*P. Both limits are inclusive.
- R6: The first rising edge after power-good only starts the measurement. Lock (sync_ext_o high) is declared after LOCK_N consecutive valid periods, so with LOCK_N = 4 it comes on the fifth edge and not on the fourth.
- R7: While locked, every sync rising edge restarts the cycle. Channel one then pulses every P cycles, and channel three pulses floor(P/2) cycles after channel one.
- R8: If no sync edge arrives within INT_PER + MARGIN cycles of the last one, lock is dropped. The first internal pulse follows exactly INT_PER cycles after the last sync-driven pulse.
- R9: sync_fault_o rises on a rejected period while pg_i is high. It clears on lock, on pg_i low, or after QUIET_PER*INT_PER cycles without a sync edge. It is never high together with sync_ext_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Asynchronous external sync pin |
| pg_i | input | 1 | Power-good flag; gates use of the sync pin |
| cyc_start_o | output | 3 | One-cycle start pulse per channel; bit 2 is the lagging channel |
| sync_ext_o | output | 1 | High while timing follows the external source |
| sync_fault_o | output | 1 | High while a sync source is present but rejected |

## Verification
The bench builds the block with its default parameters, which match the 50 MHz bench clock. The internal period is therefore 50 cycles, the acceptance window is 22 to 47 cycles, the fallback timeout is 58 cycles and the quiet time is 200 cycles. At these sizes the bench can drive periods one cycle inside and one cycle outside each frequency limit. It also drives high times on both sides of the 40% and 60% duty bounds, and it can count the exact lock edge. The hand-over back to the internal counter is measured to the cycle, and each scenario still takes only a few hundred clocks.

// File: rtl/mpclk_pkg.sv
package mpclk_pkg;
  localparam int PCT = 100;
  typedef enum logic {PH_LEAD = 1'b0, PH_LAG = 1'b1} phase_e;
endpackage

// File: rtl/mpclk_sync_in.sv
module mpclk_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sync_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mpclk_period_meter.sv
module mpclk_period_meter
  import mpclk_pkg::*;
#(
  parameter int CW       = 8,
  parameter int MIN_PER  = 22,
  parameter int MAX_PER  = 47,
  parameter int DUTY_MIN = 40,
  parameter int DUTY_MAX = 60,
  parameter int TIMEOUT  = 58,
  parameter int QUIET    = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          meas_o,
  output logic          ok_o,
  output logic [CW-1:0] per_o,
  output logic          timeout_o,
  output logic          quiet_o
);
  logic [CW-1:0] cnt_q, hi_q;
  logic          have_prev_q, hi_vld_q;
  int            per_len, hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      hi_q        <= '0;
      have_prev_q <= 1'b0;
      hi_vld_q    <= 1'b0;
    end else if (!en_i) begin
      cnt_q       <= '0;
      hi_q        <= '0;
      have_prev_q <= 1'b0;
      hi_vld_q    <= 1'b0;
    end else if (rise_i) begin
      cnt_q       <= '0;
      have_prev_q <= 1'b1;
      hi_vld_q    <= 1'b0;
    end else begin
      if (cnt_q != CW'(QUIET)) cnt_q <= cnt_q + CW'(1);
      else                     have_prev_q <= 1'b0;  // source gone, restart measurement
      if (fall_i && have_prev_q) begin
        hi_q     <= cnt_q + CW'(1);
        hi_vld_q <= 1'b1;
      end
    end
  end

  always_comb begin
    per_len = int'(cnt_q) + 1;
    hi_len  = int'(hi_q);
    ok_o    = hi_vld_q && (per_len >= MIN_PER) && (per_len <= MAX_PER) &&
              (hi_len * PCT >= DUTY_MIN * per_len) &&
              (hi_len * PCT <= DUTY_MAX * per_len);
  end

  assign meas_o    = en_i && rise_i && have_prev_q;
  assign per_o     = CW'(per_len);
  assign timeout_o = have_prev_q && (cnt_q >= CW'(TIMEOUT));
  assign quiet_o   = (cnt_q == CW'(QUIET));
endmodule

// File: rtl/mpclk_lock_ctrl.sv
module mpclk_lock_ctrl #(
  parameter int LOCK_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic meas_i,
  input  logic ok_i,
  input  logic timeout_i,
  input  logic quiet_i,
  output logic locked_o,
  output logic fault_o
);
  localparam int GW = $clog2(LOCK_N + 1);

  logic [GW-1:0] good_q;
  logic          bad, good, reach;

  assign bad   = meas_i && !ok_i;
  assign good  = meas_i && ok_i;
  assign reach = good && (good_q >= GW'(LOCK_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q   <= '0;
      locked_o <= 1'b0;
      fault_o  <= 1'b0;
    end else if (!en_i) begin
      good_q   <= '0;
      locked_o <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      if (bad || timeout_i) begin
        good_q   <= '0;
        locked_o <= 1'b0;
      end else if (good) begin
        if (good_q < GW'(LOCK_N)) good_q <= good_q + GW'(1);
        if (reach) locked_o <= 1'b1;
      end
      if (bad)                  fault_o <= 1'b1;
      else if (reach || quiet_i) fault_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mpclk_phase_gen.sv
module mpclk_phase_gen
  import mpclk_pkg::*;
#(
  parameter int         INT_PER  = 50,
  parameter int         CW       = 8,
  parameter int         NCH      = 3,
  parameter logic [2:0] LAG_MASK = 3'b100
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           locked_i,
  input  logic           rise_i,
  input  logic           upd_i,
  input  logic [CW-1:0]  per_i,
  output logic [NCH-1:0] cyc_o
);
  localparam int PW = $clog2(INT_PER);

  logic [PW-1:0] ph_q, half_q, half_sel;
  logic          start_a, start_b, wrap;

  assign wrap     = (ph_q == PW'(INT_PER - 1));
  assign start_a  = (locked_i && rise_i) || wrap;
  assign half_sel = locked_i ? half_q : PW'(INT_PER / 2);
  assign start_b  = !start_a && (ph_q == half_sel - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      half_q <= PW'(INT_PER / 2);
    end else begin
      ph_q <= start_a ? '0 : ph_q + PW'(1);
      if (upd_i) half_q <= PW'(per_i >> 1);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    phase_e sel;
    assign sel = phase_e'(LAG_MASK[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cyc_o[i] <= 1'b0;
      else         cyc_o[i] <= (sel == PH_LAG) ? start_b : start_a;
    end
  end
endmodule

// File: rtl/multiphase_clk.sv
module multiphase_clk #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int FSW_HZ       = 1_000_000,
  parameter int SYNC_MIN_HZ  = 1_050_000,
  parameter int SYNC_MAX_HZ  = 2_310_000,
  parameter int DUTY_MIN_PCT = 40,
  parameter int DUTY_MAX_PCT = 60,
  parameter int LOCK_N       = 4,
  parameter int MARGIN       = 8,
  parameter int QUIET_PER    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       pg_i,
  output logic [2:0] cyc_start_o,
  output logic       sync_ext_o,
  output logic       sync_fault_o
);
  localparam int INT_PER = CLK_HZ / FSW_HZ;
  localparam int MAX_PER = CLK_HZ / SYNC_MIN_HZ;
  localparam int MIN_PER = (CLK_HZ + SYNC_MAX_HZ - 1) / SYNC_MAX_HZ;
  localparam int TIMEOUT = INT_PER + MARGIN;
  localparam int QUIET   = QUIET_PER * INT_PER;
  localparam int CW      = $clog2(QUIET + 1);

  logic          rise, fall, meas, ok, tmo, quiet, locked;
  logic [CW-1:0] per;

  mpclk_sync_in #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .sync_i, .rise_o(rise), .fall_o(fall)
  );

  mpclk_period_meter #(
    .CW(CW), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER),
    .DUTY_MIN(DUTY_MIN_PCT), .DUTY_MAX(DUTY_MAX_PCT),
    .TIMEOUT(TIMEOUT), .QUIET(QUIET)
  ) u_meter (
    .clk_i, .rst_ni, .en_i(pg_i), .rise_i(rise), .fall_i(fall),
    .meas_o(meas), .ok_o(ok), .per_o(per), .timeout_o(tmo), .quiet_o(quiet)
  );

  mpclk_lock_ctrl #(.LOCK_N(LOCK_N)) u_lock (
    .clk_i, .rst_ni, .en_i(pg_i), .meas_i(meas), .ok_i(ok),
    .timeout_i(tmo), .quiet_i(quiet), .locked_o(locked), .fault_o(sync_fault_o)
  );

  mpclk_phase_gen #(
    .INT_PER(INT_PER), .CW(CW), .NCH(3), .LAG_MASK(3'b100)
  ) u_phase (
    .clk_i, .rst_ni, .locked_i(locked), .rise_i(rise),
    .upd_i(meas && ok), .per_i(per), .cyc_o(cyc_start_o)
  );

  assign sync_ext_o = locked;
endmodule

// File: rtl/mpclk_chk.sv
module mpclk_chk #(
  parameter int INT_PER = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pg_i,
  input logic [2:0] cyc_i,
  input logic       ext_i,
  input logic       fault_i
);
  int gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= 0;
    else if (cyc_i[0]) gap_q <= 1;
    else if (gap_q <= INT_PER + 4) gap_q <= gap_q + 1;
  end

  assert_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i[0] |=> !cyc_i[0]);
  assert_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i[0] == cyc_i[1]);
  assert_antiphase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i[0] |-> !cyc_i[2]);
  assert_pg_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_i |=> !ext_i);
  assert_lock_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_i) |-> $past(pg_i));
  // slack of one cycle for the reset-release phase
  assert_no_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= INT_PER + 1);
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_i && fault_i));
endmodule

bind multiphase_clk mpclk_chk #(.INT_PER(INT_PER)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pg_i(pg_i), .cyc_i(cyc_start_o),
  .ext_i(sync_ext_o), .fault_i(sync_fault_o)
);

// File: tb/tb_multiphase_clk.sv
module tb_multiphase_clk;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       pg_i = 1'b0;
  logic [2:0] cyc_start_o;
  logic       sync_ext_o, sync_fault_o;

  int checks = 0, errors = 0;
  int cyc = 0, last_a = 0, prev_a = 0, b_off = 0, ch_mis = 0;
  bit done = 1'b0;

  localparam int INT_PER = 50;

  multiphase_clk dut (
    .clk_i, .rst_ni, .sync_i, .pg_i, .cyc_start_o, .sync_ext_o, .sync_fault_o
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (cyc_start_o[0]) begin prev_a = last_a; last_a = cyc; end
    if (cyc_start_o[2]) b_off = cyc - last_a;
    if (cyc_start_o[0] != cyc_start_o[1]) ch_mis++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic burst(input int per, input int hi, input int n);
    for (int i = 0; i < n; i++) begin
      sync_i = 1'b1;
      repeat (hi) @(negedge clk_i);
      sync_i = 1'b0;
      repeat (per - hi) @(negedge clk_i);
    end
  endtask

  task automatic pg_cycle();
    pg_i = 1'b0;
    repeat (4) @(negedge clk_i);
    pg_i = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk_i);
    chk(cyc_start_o == 3'b000, "R1 reset pulses", int'(cyc_start_o), 0);
    chk(sync_ext_o == 1'b0, "R3 reset ext", int'(sync_ext_o), 0);
    chk(sync_fault_o == 1'b0, "R9 reset fault", int'(sync_fault_o), 0);
  endtask

  task automatic t_internal();
    repeat (160) @(negedge clk_i);
    chk(last_a - prev_a == INT_PER, "R1 internal period", last_a - prev_a, INT_PER);
    chk(b_off == INT_PER / 2, "R2 internal ch3 offset", b_off, INT_PER / 2);
    chk(ch_mis == 0, "R2 ch1/ch2 coincide", ch_mis, 0);
  endtask

  task automatic t_pg_gate();
    pg_i = 1'b0;
    burst(40, 20, 10);
    chk(sync_ext_o == 1'b0, "R3 no lock without pg", int'(sync_ext_o), 0);
    chk(sync_fault_o == 1'b0, "R3 no fault without pg", int'(sync_fault_o), 0);
    chk(last_a - prev_a == INT_PER, "R3 internal period kept", last_a - prev_a, INT_PER);
  endtask

  task automatic t_lock();
    pg_cycle();
    burst(40, 20, 4);
    chk(sync_ext_o == 1'b0, "R6 no lock after 4 edges", int'(sync_ext_o), 0);
    burst(40, 20, 1);
    chk(sync_ext_o == 1'b1, "R6 lock on 5th edge", int'(sync_ext_o), 1);
    burst(40, 20, 3);
    chk(last_a - prev_a == 40, "R7 locked period", last_a - prev_a, 40);
    chk(b_off == 20, "R7 locked ch3 offset", b_off, 20);
    chk(sync_fault_o == 1'b0, "R9 no fault while locked", int'(sync_fault_o), 0);
  endtask

  task automatic t_fallback();
    int t0 = last_a;
    int w = 0;
    while (last_a == t0 && w < 200) begin
      @(negedge clk_i);
      w++;
    end
    chk(last_a - t0 == INT_PER, "R8 first internal pulse after sync stop", last_a - t0, INT_PER);
    repeat (120) @(negedge clk_i);
    chk(sync_ext_o == 1'b0, "R8 lock dropped", int'(sync_ext_o), 0);
    chk(sync_fault_o == 1'b0, "R9 silence is no fault", int'(sync_fault_o), 0);
    chk(last_a - prev_a == INT_PER, "R8 internal period resumed", last_a - prev_a, INT_PER);
    chk(b_off == INT_PER / 2, "R8 ch3 back to half internal", b_off, INT_PER / 2);
  endtask

  task automatic t_pg_drop();
    pg_cycle();
    burst(40, 20, 6);
    chk(sync_ext_o == 1'b1, "R3 relocked", int'(sync_ext_o), 1);
    pg_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(sync_ext_o == 1'b0, "R3 pg drop clears lock", int'(sync_ext_o), 0);
    repeat (120) @(negedge clk_i);
  endtask

  task automatic t_case(input string req, input int per, input int hi, input bit acc);
    pg_cycle();
    burst(per, hi, 8);
    chk(sync_ext_o == acc, {req, " lock decision"}, int'(sync_ext_o), int'(acc));
    chk(sync_fault_o == !acc, {req, " fault flag"}, int'(sync_fault_o), int'(!acc));
    if (acc) begin
      chk(last_a - prev_a == per, {req, " followed period"}, last_a - prev_a, per);
      chk(b_off == per / 2, {req, " ch3 at half"}, b_off, per / 2);
    end else begin
      chk(last_a - prev_a == INT_PER, {req, " internal kept"}, last_a - prev_a, INT_PER);
    end
  endtask

  task automatic t_window();
    t_case("R4 min period 22", 22, 11, 1'b1);
    t_case("R4 max period 47", 47, 24, 1'b1);
    t_case("R4 too fast 21", 21, 10, 1'b0);
    t_case("R4 too slow 48", 48, 24, 1'b0);
  endtask

  task automatic t_duty();
    t_case("R5 duty 40pct", 40, 16, 1'b1);
    t_case("R5 duty 60pct", 40, 24, 1'b1);
    t_case("R5 duty low", 40, 15, 1'b0);
    t_case("R5 duty high", 40, 25, 1'b0);
  endtask

  task automatic t_fault_clear();
    chk(sync_fault_o == 1'b1, "R9 fault held while rejected", int'(sync_fault_o), 1);
    repeat (250) @(negedge clk_i);
    chk(sync_fault_o == 1'b0, "R9 fault clears after quiet", int'(sync_fault_o), 0);
    burst(48, 24, 3);
    chk(sync_fault_o == 1'b1, "R9 fault set again", int'(sync_fault_o), 1);
    pg_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(sync_fault_o == 1'b0, "R9 pg low clears fault", int'(sync_fault_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_internal();
    t_pg_gate();
    t_lock();
    t_fallback();
    t_pg_drop();
    t_window();
    t_duty();
    t_fault_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule